// File: doc/BRIEF.md
# Multi-format audio serial receiver

The block turns a stereo serial audio stream into parallel left and right words. The stream arrives as three lines: a bit clock, a frame clock and a data line. All three are sampled in the block's own clock domain. A bit is taken from the data line on each rising edge of the bit clock. The frame clock tells the two channels of a frame apart. Words arrive most significant bit first in two's-complement form.

A 2-bit format select chooses the framing:

| Code | Framing | Word placement | Left channel |
|------|---------|----------------|--------------|
| 0 | 16-bit, LSB-justified | last 16 bit slots before the next frame-clock edge | frame clock high |
| 1 | 20-bit, LSB-justified | last 20 bit slots before the next frame-clock edge | frame clock high |
| 2 | 20-bit, MSB-justified | first 20 bit slots after the frame-clock edge | frame clock high |
| 3 | I2S | starts one slot after the frame-clock edge | frame clock low |

For the LSB-justified codes, the block keeps a window of the most recent bits. It takes the word from that window when the frame clock changes. For the MSB-justified and I2S codes, it counts bit clocks from the half-frame edge and places each bit by that count.

A controller walks through four named states:
- PRIME: the first bit clock after reset or resync, used only to learn the frame-clock level.
- SEEK: waits for a frame-clock edge.
- LEFT: a left half-frame is being received.
- RIGHT: a right half-frame is being received.

The transitions are:
- PRIME→SEEK on the next bit-clock edge.
- SEEK→LEFT or SEEK→RIGHT on a frame-clock edge, depending on which channel starts.
- LEFT→RIGHT on a frame-clock edge, capturing the left word.
- RIGHT→LEFT on a frame-clock edge, capturing the right word and pulsing the valid output.
- Any state→PRIME when the format select changes.

The bit clock must stay at least two system clocks in each phase.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, frame_valid is 0 and both words are 0.
- R2: Format 0 takes the last 16 bits before a half-frame ends, most significant bit first. The word is presented as those 16 bits in bits 19..4, with bits 3..0 set to zero.
- R3: Format 1 takes the last 20 bits before a half-frame ends, most significant bit first, as bits 19..0.
- R4: Format 2 takes the first 20 bits of a half-frame, starting at the bit sampled on the first rising bit-clock edge after the frame-clock change. If a half-frame carries fewer than 20 bits, the missing low bits read as zero.
- R5: Format 3 takes up to 20 bits that start one bit slot after the frame-clock change. Missing low bits read as zero.
- R6: Frame clock high marks the left channel in formats 0 to 2. Frame clock low marks the left channel in format 3.
- R7: Bit slots outside the word have no effect on either output word.
- R8: frame_valid pulses for one cycle after each right word ends, and only when a complete left half preceded it. The words change only in that cycle. The partial half-frame before the first frame-clock edge is discarded.
- R9: A change of the format select discards any partly received frame. No pulse is raised until a full new left half and right half have arrived.
- R10: Half-frames of 16, 20 and 32 bit clocks are handled, which corresponds to 32, 40 and 64 bit clocks per sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing code, 0 to 3 as in R2 to R5 |
| bclk_in | input | 1 | Serial bit clock |
| lrck_in | input | 1 | Frame clock |
| sdat_in | input | 1 | Serial data |
| left_word | output | 20 | Left channel word |
| right_word | output | 20 | Right channel word |
| frame_valid | output | 1 | One-cycle pulse when a new word pair is presented |

## Verification
The hardest situation to reach is a format change that arrives while a left word is already captured and a right half is partly received. If the stale left word survived, it would pair with the next right word. The stimulus reaches this state deliberately: it sends a lead-in half, one whole left half and a few right bits, then switches format and expects no pulse in that run. Short half-frames in the MSB-justified and I2S formats are also hard to cover, because they truncate the word. The runs at 16 slots per half cover them, and every unused slot is filled with random bits.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_LSB16 = 2'd0,
        FMT_LSB20 = 2'd1,
        FMT_MSB20 = 2'd2,
        FMT_I2S   = 2'd3
    } rx_fmt_e;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_SEEK  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } rx_state_e;

endpackage

// File: rtl/aud_rx_pins.sv
module aud_rx_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrck_in,
    input  logic sdat_in,
    output logic strobe,
    output logic sd,
    output logic lr
);
    logic bclk_q;
    logic bclk_q2;
    logic lrck_q;
    logic sdat_q;

    // Register the serial lines once; a second bit-clock stage finds the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_q2 <= 1'b0;
            lrck_q  <= 1'b0;
            sdat_q  <= 1'b0;
        end else begin
            bclk_q  <= bclk_in;
            bclk_q2 <= bclk_q;
            lrck_q  <= lrck_in;
            sdat_q  <= sdat_in;
        end
    end

    assign strobe = bclk_q & ~bclk_q2;
    assign sd     = sdat_q;
    assign lr     = lrck_q;

endmodule

// File: rtl/aud_rx_slots.sv
module aud_rx_slots
    import aud_rx_pkg::*;
#(
    parameter int WORD_W        = 20,
    parameter int SHORT_W       = 16,
    parameter int MAX_HALF_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              strobe,
    input  logic              sd,
    input  logic              lr,
    input  rx_fmt_e           fmt,
    output logic              edge_hit,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(MAX_HALF_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_HALF_BITS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic              lr_prev_q;
    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              off;

    // I2S data starts one slot after the frame-clock edge.
    assign off      = (fmt == FMT_I2S);
    assign edge_hit = strobe && (lr != lr_prev_q);

    // Slot-addressed accumulator for the edge-anchored formats.
    for (genvar g = 0; g < WORD_W; g++) begin : g_acc
        if (g == WORD_W - 1) begin : g_top
            assign acc_d[g] = edge_hit ? (sd & ~off)
                            : ((int'(cnt_q) == int'(off) + (WORD_W - 1 - g)) ? sd : acc_q[g]);
        end else begin : g_rest
            assign acc_d[g] = edge_hit ? 1'b0
                            : ((int'(cnt_q) == int'(off) + (WORD_W - 1 - g)) ? sd : acc_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev_q <= 1'b0;
            win_q     <= '0;
            acc_q     <= '0;
            cnt_q     <= '0;
        end else begin
            if (resync) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (strobe) begin
                acc_q <= acc_d;
                win_q <= {win_q[WORD_W-2:0], sd};
                if (edge_hit) begin
                    cnt_q <= CNT_ONE;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + CNT_ONE;
                end
            end
            if (strobe) begin
                lr_prev_q <= lr;
            end
        end
    end

    // Word from the half-frame that ends at the current edge.
    always_comb begin
        unique case (fmt)
            FMT_LSB16: word = {win_q[SHORT_W-1:0], {(WORD_W - SHORT_W){1'b0}}};
            FMT_LSB20: word = win_q;
            FMT_MSB20: word = acc_q;
            FMT_I2S:   word = acc_q;
            default:   word = acc_q;
        endcase
    end

    // R3: the newest sampled bit sits at the bottom of the window
    a_r3_window_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !resync) |=> (win_q[0] == $past(sd)));

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              strobe,
    input  logic              edge_hit,
    input  logic              lr,
    input  rx_fmt_e           fmt,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              frame_valid
);
    rx_state_e         state_q;
    rx_state_e         state_d;
    logic              have_left_q;
    logic [WORD_W-1:0] left_stage_q;
    logic              new_is_left;
    logic              fire;

    assign new_is_left = (fmt == FMT_I2S) ? ~lr : lr;
    assign fire = !resync && (state_q == ST_RIGHT) && edge_hit && have_left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (resync) begin
            state_d = ST_PRIME;
        end else begin
            unique case (state_q)
                ST_PRIME: if (strobe)   state_d = ST_SEEK;
                ST_SEEK:  if (edge_hit) state_d = new_is_left ? ST_LEFT : ST_RIGHT;
                ST_LEFT:  if (edge_hit) state_d = ST_RIGHT;
                ST_RIGHT: if (edge_hit) state_d = ST_LEFT;
                default:                state_d = ST_PRIME;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_left_q  <= 1'b0;
            left_stage_q <= '0;
            left_word    <= '0;
            right_word   <= '0;
            frame_valid  <= 1'b0;
        end else begin
            frame_valid <= fire;
            if (resync) begin
                have_left_q <= 1'b0;
            end else if ((state_q == ST_LEFT) && edge_hit) begin
                left_stage_q <= word;
                have_left_q  <= 1'b1;
            end else if ((state_q == ST_PRIME) || (state_q == ST_SEEK)) begin
                have_left_q <= 1'b0;
            end
            if (fire) begin
                left_word  <= left_stage_q;
                right_word <= word;
            end
        end
    end

    // R8: the valid strobe lasts one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R8: words move only together with the strobe
    a_r8_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_word) && $stable(right_word)));

    // R8: a strobe follows the end of a right half
    a_r8_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(state_q) == ST_RIGHT));

    // R9: a format change restarts framing with no strobe
    a_r9_resync: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> ((state_q == ST_PRIME) && !frame_valid));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int WORD_W        = 20,
    parameter int SHORT_W       = 16,
    parameter int MAX_HALF_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              bclk_in,
    input  logic              lrck_in,
    input  logic              sdat_in,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              frame_valid
);
    logic              strobe;
    logic              sd;
    logic              lr;
    logic              edge_hit;
    logic [WORD_W-1:0] word;
    logic [1:0]        fmt_q;
    logic              resync;
    rx_fmt_e           fmt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= 2'd0;
        end else begin
            fmt_q <= fmt_sel;
        end
    end

    assign resync = (fmt_sel != fmt_q);
    assign fmt    = rx_fmt_e'(fmt_q);

    aud_rx_pins i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_in (bclk_in),
        .lrck_in (lrck_in),
        .sdat_in (sdat_in),
        .strobe  (strobe),
        .sd      (sd),
        .lr      (lr)
    );

    aud_rx_slots #(
        .WORD_W        (WORD_W),
        .SHORT_W       (SHORT_W),
        .MAX_HALF_BITS (MAX_HALF_BITS)
    ) i_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync   (resync),
        .strobe   (strobe),
        .sd       (sd),
        .lr       (lr),
        .fmt      (fmt),
        .edge_hit (edge_hit),
        .word     (word)
    );

    aud_rx_frame #(
        .WORD_W (WORD_W)
    ) i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .resync      (resync),
        .strobe      (strobe),
        .edge_hit    (edge_hit),
        .lr          (lr),
        .fmt         (fmt),
        .word        (word),
        .left_word   (left_word),
        .right_word  (right_word),
        .frame_valid (frame_valid)
    );

endmodule

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        bclk_in = 1'b0;
    logic        lrck_in = 1'b0;
    logic        sdat_in = 1'b0;
    logic [19:0] left_word;
    logic [19:0] right_word;
    logic        frame_valid;

    int n_checks = 0;
    int n_fail = 0;
    int idx = 0;
    int nexp = 0;
    int cur_mode = 0;
    bit finished = 1'b0;
    logic [19:0] exp_l [0:31];
    logic [19:0] exp_r [0:31];

    always #10 clk = ~clk;

    aud_serial_rx i_aud_serial_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_sel     (fmt_sel),
        .bclk_in     (bclk_in),
        .lrck_in     (lrck_in),
        .sdat_in     (sdat_in),
        .left_word   (left_word),
        .right_word  (right_word),
        .frame_valid (frame_valid)
    );

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Bit index of the word carried by slot k, or -1 for an unused slot.
    function automatic int slot_index(int m, int len, int k);
        case (m)
            0: return (k >= len - 16) ? 19 - (k - (len - 16)) : -1;
            1: return (k >= len - 20) ? 19 - (k - (len - 20)) : -1;
            2: return (k < 20) ? 19 - k : -1;
            default: return (k >= 1 && k <= 20) ? 20 - k : -1;
        endcase
    endfunction

    function automatic logic [19:0] expect_word(int m, int len, logic [19:0] w);
        int c;
        logic [19:0] mask;
        case (m)
            0: return {w[19:4], 4'b0};
            1: return w;
            2: c = (len < 20) ? len : 20;
            default: c = (len - 1 < 20) ? len - 1 : 20;
        endcase
        mask = 20'hFFFFF << (20 - c);
        return w & mask;
    endfunction

    task automatic check(bit ok, string req, logic [19:0] act, logic [19:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, expv);
        end
    endtask

    task automatic send_bit(bit lr, bit b);
        bclk_in = 1'b0;
        lrck_in = lr;
        sdat_in = b;
        repeat (2) @(negedge clk);
        bclk_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(int m, int len, bit lr, logic [19:0] w, int nbits);
        for (int k = 0; k < nbits; k++) begin
            int bi = slot_index(m, len, k);
            bit b = (bi < 0) ? bit'($urandom_range(0, 1)) : w[bi];   // R7: unused slots random
            send_bit(lr, b);
        end
    endtask

    // One run: resync, lead-in half, nf frames, closing half.
    task automatic run(int m, int len, int nf, bit abort);
        bit left_lr = (m == 3) ? 1'b0 : 1'b1;   // R6 polarity
        fmt_sel = 2'(m ^ 1);
        repeat (3) @(negedge clk);
        fmt_sel = 2'(m);
        repeat (3) @(negedge clk);
        cur_mode = m;
        idx = 0;
        nexp = abort ? 0 : nf;
        send_half(m, len, ~left_lr, 20'($urandom), len);
        if (abort) begin
            send_half(m, len, left_lr, 20'($urandom), len);
            send_half(m, len, ~left_lr, 20'($urandom), 5);
            repeat (4) @(negedge clk);
            check(idx == 0, "R9", 20'(idx), 20'd0);
            return;
        end
        for (int f = 0; f < nf; f++) begin
            logic [19:0] wl = (f == 0) ? 20'h7FFFF : 20'($urandom);
            logic [19:0] wr = (f == 0) ? 20'h80000 : 20'($urandom);
            exp_l[f] = expect_word(m, len, wl);
            exp_r[f] = expect_word(m, len, wr);
            send_half(m, len, left_lr, wl, len);
            send_half(m, len, ~left_lr, wr, len);
        end
        send_half(m, len, left_lr, 20'($urandom), len);
        repeat (4) @(negedge clk);
        // R8 and R10: exactly one pulse per frame at this half-frame length
        check(idx == nf, "R8/R10", 20'(idx), 20'(nf));
    endtask

    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            if (idx < nexp) begin
                check(left_word == exp_l[idx], {mode_tag(cur_mode), "/R6 left"}, left_word, exp_l[idx]);
                check(right_word == exp_r[idx], {mode_tag(cur_mode), "/R7 right"}, right_word, exp_r[idx]);
            end else begin
                check(1'b0, "R8 unexpected pulse", 20'(idx), 20'(nexp));
            end
            idx++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(frame_valid == 1'b0, "R1 valid", 20'(frame_valid), 20'd0);
        check(left_word == 20'd0, "R1 left", left_word, 20'd0);
        check(right_word == 20'd0, "R1 right", right_word, 20'd0);

        run(0, 16, 6, 1'b0);
        run(0, 20, 5, 1'b0);
        run(0, 32, 5, 1'b0);
        run(1, 20, 6, 1'b0);
        run(1, 32, 5, 1'b0);
        run(2, 16, 5, 1'b0);
        run(2, 20, 5, 1'b0);
        run(2, 32, 6, 1'b0);
        run(2, 32, 3, 1'b1);     // R9 abort in the middle of a frame
        run(1, 32, 4, 1'b0);
        run(3, 16, 5, 1'b0);
        run(3, 20, 5, 1'b0);
        run(3, 32, 6, 1'b0);
        run(3, 32, 3, 1'b1);
        run(0, 32, 4, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule